// File: doc/BRIEF.md
# Micro-TLB with Selective Invalidation

A small, fully associative translation cache that sits in front of a larger, less associative main TLB. Each lookup compares a virtual page number and address-space identifier against every stored entry in the same cycle. A hit returns the physical page number combinationally. A miss starts a refill request toward the main TLB. The returned entry is installed into a slot chosen by a round-robin pointer.

Entries are removed only by an explicit invalidate pulse. The pulse is raised by the surrounding logic for a normal main-TLB write or for a dedicated invalidate command. A main-TLB write that is meant to keep the micro-TLB does not raise it. A main-TLB victim replacement does not raise it either. Entries therefore outlive their main-TLB copies, and the higher associativity here hides set conflicts in the main TLB.

Two instances are used: one for data with `ENTRIES = 8` and one for instruction fetch with `ENTRIES = 4`.

Top module: `micro_tlb`

## Requirements
- R1: After reset no entry is valid: `hit_o` is 0 for any lookup and `refill_req_o` is 0.
- R2: A lookup hits only if some entry is valid, its page number equals `lookup_vpn_i`, and either its ASID equals `lookup_asid_i` or its global flag is 1. `hit_o` is combinational from the lookup inputs.
- R3: When a lookup misses while no refill is pending, `refill_req_o` rises after the next clock edge. The lookup's page number and ASID appear on `refill_vpn_o`/`refill_asid_o`. The request is held until `refill_ack_i` is sampled high.
- R4: On the edge where `refill_ack_i` is high with a request pending, the request drops. The entry (requested page and ASID, plus `refill_ppn_i` and `refill_global_i`) becomes valid. A following lookup of that page returns its PPN on `hit_ppn_o`.
- R5: While a request is pending, further lookups, whether they hit or miss, leave the request outputs unchanged.
- R6: Slots are replaced in round-robin order over all `ENTRIES` slots. After `ENTRIES` installs, the next install evicts the oldest one. The pointer moves only on an install and is not changed by invalidation.
- R7: A pulse on `flush_i` makes every entry invalid from the next cycle. Without it, installed entries stay valid for any length of time.
- R8: If `flush_i` and `refill_ack_i` are high in the same cycle, the flush wins. The returned entry is discarded, and the request still ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lookup_valid_i | input | 1 | Lookup request this cycle |
| lookup_vpn_i | input | VPN_W | Virtual page number to translate |
| lookup_asid_i | input | ASID_W | Current address-space identifier |
| hit_o | output | 1 | Lookup hit |
| hit_ppn_o | output | PPN_W | Physical page number of the hit entry |
| refill_req_o | output | 1 | Refill request to main TLB |
| refill_vpn_o | output | VPN_W | Page number being requested |
| refill_asid_o | output | ASID_W | ASID being requested |
| refill_ack_i | input | 1 | Main TLB returns the entry |
| refill_ppn_i | input | PPN_W | Returned physical page number |
| refill_global_i | input | 1 | Returned entry ignores ASID |
| flush_i | input | 1 | Invalidate all entries |

## Verification
Several properties are checked on every cycle. A pending request holds its page and ASID until acknowledged. An acknowledged install makes the chosen slot valid with the requested page. A flush leaves no valid entry. The replacement pointer stays put across a flush.

Other behaviour only shows up in the bench scenarios: the hit rule's ASID and global cases, eviction of the oldest slot after a full ring of installs, retention of entries over long idle stretches, and the discarded refill when a flush and an acknowledge coincide.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } refill_state_e;
endpackage

// File: rtl/utlb_store.sv
module utlb_store #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PPN_W   = 20,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              match_o,
  output logic [PPN_W-1:0]  match_ppn_o,
  input  logic              wr_en_i,
  input  logic [IW-1:0]     wr_idx_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [PPN_W-1:0]  wr_ppn_i,
  input  logic              wr_glb_i,
  input  logic              flush_i
);
  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [ENTRIES-1:0] glb_q;
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn_i) &&
                      (glb_q[g] || (asid_q[g] == lk_asid_i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        glb_q[g]   <= 1'b0;
        vpn_q[g]   <= '0;
        asid_q[g]  <= '0;
        ppn_q[g]   <= '0;
      end else if (flush_i) begin
        valid_q[g] <= 1'b0;  // invalidate beats a same-cycle install
      end else if (wr_en_i && (wr_idx_i == IW'(g))) begin
        valid_q[g] <= 1'b1;
        glb_q[g]   <= wr_glb_i;
        vpn_q[g]   <= wr_vpn_i;
        asid_q[g]  <= wr_asid_i;
        ppn_q[g]   <= wr_ppn_i;
      end
    end
  end

  assign match_o = |match;

  always_comb begin
    match_ppn_o = '0;
    for (int k = 0; k < ENTRIES; k++)
      if (match[k]) match_ppn_o = match_ppn_o | ppn_q[k];
  end

  assert_flush_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));

  assert_install_lands_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !flush_i) |=> (valid_q[$past(wr_idx_i)] &&
                               vpn_q[$past(wr_idx_i)] == $past(wr_vpn_i)));
endmodule

// File: rtl/utlb_rr.sv
module utlb_rr #(
  parameter int ENTRIES = 8,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          flush_i,
  output logic [IW-1:0] ptr_o
);
  logic [IW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == IW'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  assert_ptr_keeps_on_flush_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !adv_i) |=> $stable(ptr_q));

  assert_ptr_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= IW'(ENTRIES - 1));
endmodule

// File: rtl/utlb_refill.sv
module utlb_refill
  import utlb_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic              lk_hit_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [VPN_W-1:0]  req_vpn_o,
  output logic [ASID_W-1:0] req_asid_o,
  output logic              install_o
);
  refill_state_e     state_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vpn_q   <= '0;
      asid_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (lk_valid_i && !lk_hit_i) begin
          state_q <= ST_WAIT;
          vpn_q   <= lk_vpn_i;
          asid_q  <= lk_asid_i;
        end
        ST_WAIT: if (ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o      = (state_q == ST_WAIT);
  assign req_vpn_o  = vpn_q;
  assign req_asid_o = asid_q;
  assign install_o  = req_o && ack_i;

  assert_req_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(req_vpn_o) && $stable(req_asid_o)));

  assert_req_ends_on_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i) |=> !req_o);
endmodule

// File: rtl/micro_tlb.sv
module micro_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PPN_W   = 20,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [VPN_W-1:0]  lookup_vpn_i,
  input  logic [ASID_W-1:0] lookup_asid_i,
  output logic              hit_o,
  output logic [PPN_W-1:0]  hit_ppn_o,
  output logic              refill_req_o,
  output logic [VPN_W-1:0]  refill_vpn_o,
  output logic [ASID_W-1:0] refill_asid_o,
  input  logic              refill_ack_i,
  input  logic [PPN_W-1:0]  refill_ppn_i,
  input  logic              refill_global_i,
  input  logic              flush_i
);
  logic          match;
  logic          install;
  logic          wr_en;
  logic [IW-1:0] victim;

  assign wr_en = install && !flush_i;

  utlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W)
  ) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_vpn_i   (lookup_vpn_i),
    .lk_asid_i  (lookup_asid_i),
    .match_o    (match),
    .match_ppn_o(hit_ppn_o),
    .wr_en_i    (wr_en),
    .wr_idx_i   (victim),
    .wr_vpn_i   (refill_vpn_o),
    .wr_asid_i  (refill_asid_o),
    .wr_ppn_i   (refill_ppn_i),
    .wr_glb_i   (refill_global_i),
    .flush_i    (flush_i)
  );

  utlb_rr #(.ENTRIES(ENTRIES)) i_rr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (wr_en),
    .flush_i(flush_i),
    .ptr_o  (victim)
  );

  utlb_refill #(.VPN_W(VPN_W), .ASID_W(ASID_W)) i_refill (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_valid_i(lookup_valid_i),
    .lk_hit_i  (match),
    .lk_vpn_i  (lookup_vpn_i),
    .lk_asid_i (lookup_asid_i),
    .ack_i     (refill_ack_i),
    .req_o     (refill_req_o),
    .req_vpn_o (refill_vpn_o),
    .req_asid_o(refill_asid_o),
    .install_o (install)
  );

  assign hit_o = lookup_valid_i && match;

  assert_no_req_on_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!refill_req_o && hit_o) |=> !refill_req_o);
endmodule

// File: tb/test_micro_tlb.sv
module test_micro_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int N      = 8;
  localparam int VPN_W  = 20;
  localparam int ASID_W = 8;
  localparam int PPN_W  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_v = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic hit;
  logic [PPN_W-1:0] hit_ppn;
  logic req;
  logic [VPN_W-1:0] req_vpn;
  logic [ASID_W-1:0] req_asid;
  logic ack = 1'b0;
  logic [PPN_W-1:0] ack_ppn = '0;
  logic ack_glb = 1'b0;
  logic flush = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  micro_tlb #(.ENTRIES(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W)) i_micro_tlb (
    .clk_i(clk), .rst_ni(rst_n),
    .lookup_valid_i(lk_v), .lookup_vpn_i(lk_vpn), .lookup_asid_i(lk_asid),
    .hit_o(hit), .hit_ppn_o(hit_ppn),
    .refill_req_o(req), .refill_vpn_o(req_vpn), .refill_asid_o(req_asid),
    .refill_ack_i(ack), .refill_ppn_i(ack_ppn), .refill_global_i(ack_glb),
    .flush_i(flush)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [VPN_W-1:0] vpn_of(input int i);
    return VPN_W'(i * 3 + 1);
  endfunction

  function automatic logic [PPN_W-1:0] ppn_of(input int i);
    return PPN_W'(i * 7 + 100);
  endfunction

  // combinational probe within one low phase, no request can start
  task automatic probe(input string tag, input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                       input logic exp_hit, input logic [PPN_W-1:0] exp_ppn);
    @(negedge clk);
    lk_v = 1'b1; lk_vpn = v; lk_asid = a;
    #1;
    check(tag, 32'(hit), 32'(exp_hit));
    if (exp_hit) check(tag, 32'(hit_ppn), 32'(exp_ppn));
    lk_v = 1'b0;
  endtask

  task automatic refill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                        input logic [PPN_W-1:0] p, input logic g);
    @(negedge clk);
    lk_v = 1'b1; lk_vpn = v; lk_asid = a;
    #1 check("R2 miss before refill", 32'(hit), 0);
    @(negedge clk);
    check("R3 req raised", 32'(req), 1);
    check("R3 req vpn", 32'(req_vpn), 32'(v));
    check("R3 req asid", 32'(req_asid), 32'(a));
    repeat (2) @(negedge clk);
    check("R3 req held", 32'(req), 1);
    ack = 1'b1; ack_ppn = p; ack_glb = g;
    @(negedge clk);
    ack = 1'b0;
    check("R4 req dropped", 32'(req), 0);
    check("R4 hit after install", 32'(hit), 1);
    check("R4 ppn after install", 32'(hit_ppn), 32'(p));
    lk_v = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    for (int i = 0; i < 4; i++) probe("R1 empty after reset", vpn_of(i), 8'd5, 1'b0, '0);
    check("R1 no req after reset", 32'(req), 0);

    // fill every slot; slot 2 is global
    for (int i = 0; i < N; i++) refill(vpn_of(i), 8'd5, ppn_of(i), i == 2);

    // R7 retention over idle time
    repeat (50) @(negedge clk);
    for (int i = 0; i < N; i++) probe("R7 entries retained", vpn_of(i), 8'd5, 1'b1, ppn_of(i));

    // R2 ASID / global sweep
    for (int i = 0; i < N; i++) probe("R2 other asid", vpn_of(i), 8'd6, i == 2, ppn_of(i));
    probe("R2 absent vpn", VPN_W'(1000), 8'd5, 1'b0, '0);

    // R6 ninth install evicts first
    refill(VPN_W'(500), 8'd5, PPN_W'(900), 1'b0);
    probe("R6 oldest evicted", vpn_of(0), 8'd5, 1'b0, '0);
    for (int i = 1; i < N; i++) probe("R6 others kept", vpn_of(i), 8'd5, 1'b1, ppn_of(i));
    // next install evicts the second oldest
    refill(VPN_W'(501), 8'd5, PPN_W'(901), 1'b0);
    probe("R6 second oldest evicted", vpn_of(1), 8'd5, 1'b0, '0);
    probe("R6 newest kept", VPN_W'(500), 8'd5, 1'b1, PPN_W'(900));

    // R5 lookups during a pending request
    @(negedge clk);
    lk_v = 1'b1; lk_vpn = VPN_W'(600); lk_asid = 8'd9;
    @(negedge clk);
    lk_vpn = VPN_W'(601);
    @(negedge clk);
    lk_vpn = VPN_W'(500); lk_asid = 8'd5;
    @(negedge clk);
    check("R5 req still pending", 32'(req), 1);
    check("R5 req vpn unchanged", 32'(req_vpn), 600);
    check("R5 req asid unchanged", 32'(req_asid), 9);
    lk_v = 1'b0;
    ack = 1'b1; ack_ppn = PPN_W'(777); ack_glb = 1'b0;
    @(negedge clk);
    ack = 1'b0;
    probe("R5 first request installed", VPN_W'(600), 8'd9, 1'b1, PPN_W'(777));

    // R7 flush clears all
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 2; i < N; i++) probe("R7 flushed", vpn_of(i), 8'd5, 1'b0, '0);
    probe("R7 flushed newest", VPN_W'(600), 8'd9, 1'b0, '0);

    // R8 flush wins over same-cycle ack
    @(negedge clk);
    lk_v = 1'b1; lk_vpn = VPN_W'(700); lk_asid = 8'd3;
    @(negedge clk);
    lk_v = 1'b0;
    check("R8 req pending", 32'(req), 1);
    ack = 1'b1; ack_ppn = PPN_W'(55); flush = 1'b1;
    @(negedge clk);
    ack = 1'b0; flush = 1'b0;
    check("R8 request ended", 32'(req), 0);
    probe("R8 entry discarded", VPN_W'(700), 8'd3, 1'b0, '0);
    check("R8 no new req", 32'(req), 0);

    // refills still work afterwards
    refill(VPN_W'(800), 8'd4, PPN_W'(66), 1'b0);
    probe("R4 post flush install", VPN_W'(800), 8'd4, 1'b1, PPN_W'(66));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule